// File: doc/BRIEF.md
# Dual-Polarity Register Bus Front End

This block sits between a host processor and the register file of a serial communications peripheral. The host reaches the peripheral over an 8-bit bidirectional data bus and a 3-bit register address. Access strobes come in pairs. The read strobe exists as an active-high line and as an active-low line, and so does the write strobe. A system wires up whichever polarity suits it and ties the other line of the pair to its inactive level. Three chip-select lines qualify every access: two are active-high and one is active-low.

A read is decoded directly from the pins. For as long as it lasts, the bus carries the contents of the addressed register. The rest of the time the bus is left floating. Write strobes are brought into the internal clock domain through a synchronizer. Each write then becomes a single-cycle enable that carries the bus data to the addressed register. Once a read ends, a single-cycle side-effect pulse goes to the register that was read, so that status registers can clear on read.

Register 0 holds serial character data. When the configured character is shorter than 8 bits, the upper bits of that register are cleared on writes and read back as zero. The register contents, the serial logic and the baud generator lie outside this block. They connect to it through a plain register-file port. The host side is a strobe bus with no handshake, so no valid/ready flow control applies.

Top module: `bif_top`

## Requirements
- R1: A read is qualified when chip select is asserted and either `rd_hi` is 1 or `rd_lo_n` is 0. While the read is qualified, `dbus` carries `reg_rd_data` with bit i on bus bit i, where bit 0 is the least significant bit.
- R2: A write is qualified when chip select is asserted and either `wr_hi` is 1 or `wr_lo_n` is 0. Each qualified write produces an enable pulse whose `reg_wr_data` equals the bus data.
- R3: Chip select is asserted only when `cs_a`=1, `cs_b`=1 and `cs_c_n`=0. With any other combination, the strobes do not drive the bus and produce no pulses.
- R4: `reg_rd_addr` follows `addr`. A write pulse sets only bit `addr` of `reg_wr_enable`, and at most one bit is ever set.
- R5: `dbus` is high impedance whenever no qualified read is present.
- R6: A write pulse lasts exactly one clock cycle and occurs once per strobe, however long the strobe is held. It is high in the cycle that follows the second rising clock edge after the write becomes qualified.
- R7: A write to register 0 clears the data bits above the character length. `char_len` is encoded as 0=5, 1=6, 2=7 and 3=8 bits. Writes to other registers pass all 8 bits unchanged.
- R8: A read of register 0 returns 0 in the bit positions above the character length, using the same encoding as R7.
- R9: When a qualified read ends, exactly one bit of `reg_rd_done` pulses for one cycle. That bit is the address that was present when the read began, and the pulse comes two rising edges after the read is released.
- R10: If a read ends in the same clock interval in which a write begins, the read-done pulse and the write pulse occur in the same cycle, each on its own register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_hi | input | 1 | Read strobe, active high |
| rd_lo_n | input | 1 | Read strobe, active low |
| wr_hi | input | 1 | Write strobe, active high |
| wr_lo_n | input | 1 | Write strobe, active low |
| cs_a | input | 1 | Chip select, active high |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| addr | input | 3 | Register address |
| dbus | inout | 8 | Host data bus |
| char_len | input | 2 | Character length code (0=5 .. 3=8 bits) |
| reg_rd_addr | output | 3 | Register index presented to the register file for reads |
| reg_rd_data | input | 8 | Contents of the indexed register |
| reg_wr_enable | output | 8 | One-hot, single-cycle write enables |
| reg_wr_data | output | 8 | Write data, masked for register 0 |
| reg_rd_done | output | 8 | One-hot, single-cycle read side-effect pulses |

## Verification
The read side-effect pulse and the write enable can land in the same cycle. This happens when the host drops a read strobe and raises a write strobe at the same instant, because both strobes pass through synchronizers of equal depth. The bench provokes this at a single clock edge. In that one step it releases a read of register 4, changes the address to 1, and asserts a write. It then requires that the monitor sees `reg_rd_done[4]` and `reg_wr_enable[1]` together in the same sample. It also requires that each pulse matches the front of its own scoreboard queue.

// File: rtl/bif_pkg.sv
package bif_pkg;
  localparam int BIF_DW = 8;
  localparam int BIF_AW = 3;

  typedef enum logic [1:0] {
    CLEN5 = 2'd0,
    CLEN6 = 2'd1,
    CLEN7 = 2'd2,
    CLEN8 = 2'd3
  } clen_e;

  // Mask that keeps the character bits for a given length code.
  function automatic logic [BIF_DW-1:0] clen_mask(input logic [1:0] code);
    logic [1:0] drop;
    drop = 2'd3 - code;
    return {BIF_DW{1'b1}} >> drop;
  endfunction
endpackage

// File: rtl/bif_cs_decode.sv
module bif_cs_decode #(
  parameter int NHI = 2,
  parameter int NLO = 1
) (
  input  logic [NHI-1:0] sel_hi,
  input  logic [NLO-1:0] sel_lo_n,
  output logic           sel_ok
);
  logic [NHI+NLO-1:0] terms;

  genvar gi;
  generate
    for (gi = 0; gi < NHI; gi++) begin : g_hi
      assign terms[gi] = sel_hi[gi];
    end
    for (gi = 0; gi < NLO; gi++) begin : g_lo
      assign terms[NHI+gi] = ~sel_lo_n[gi];
    end
  endgenerate

  assign sel_ok = &terms;
endmodule

// File: rtl/bif_strobe_qual.sv
module bif_strobe_qual (
  input  logic stb_hi,
  input  logic stb_lo_n,
  input  logic sel_ok,
  output logic active
);
  assign active = sel_ok & (stb_hi | ~stb_lo_n);
endmodule

// File: rtl/bif_sync.sv
module bif_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic level_prev
);
  logic [STAGES-1:0] chain;

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gs] <= 1'b0;
          else        chain[gs] <= chain[gs-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev <= 1'b0;
    else        level_prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/bif_onehot_dec.sv
module bif_onehot_dec #(
  parameter int AW = 3,
  localparam int N = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] idx,
  output logic [N-1:0]  hot
);
  genvar gd;
  generate
    for (gd = 0; gd < N; gd++) begin : g_bit
      assign hot[gd] = en && (idx == AW'(gd));
    end
  endgenerate

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hot));
endmodule

// File: rtl/bif_top.sv
module bif_top #(
  parameter int DW          = bif_pkg::BIF_DW,
  parameter int AW          = bif_pkg::BIF_AW,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_REG    = 0,
  localparam int NREG       = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hi,
  input  logic          rd_lo_n,
  input  logic          wr_hi,
  input  logic          wr_lo_n,
  input  logic          cs_a,
  input  logic          cs_b,
  input  logic          cs_c_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] dbus,
  input  logic [1:0]    char_len,
  output logic [AW-1:0] reg_rd_addr,
  input  logic [DW-1:0] reg_rd_data,
  output logic [NREG-1:0] reg_wr_enable,
  output logic [DW-1:0] reg_wr_data,
  output logic [NREG-1:0] reg_rd_done
);
  import bif_pkg::*;

  logic          sel_ok;
  logic          rd_act, wr_act;
  logic          rd_lvl, rd_prev, wr_lvl, wr_prev;
  logic          rd_start, rd_end, wr_start;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] len_mask;
  logic [DW-1:0] rd_val;

  // Chip select: two active-high lines, one active-low line
  bif_cs_decode #(.NHI(2), .NLO(1)) u_cs (
    .sel_hi   ({cs_b, cs_a}),
    .sel_lo_n (cs_c_n),
    .sel_ok   (sel_ok)
  );

  bif_strobe_qual u_rdq (
    .stb_hi (rd_hi), .stb_lo_n (rd_lo_n), .sel_ok (sel_ok), .active (rd_act)
  );
  bif_strobe_qual u_wrq (
    .stb_hi (wr_hi), .stb_lo_n (wr_lo_n), .sel_ok (sel_ok), .active (wr_act)
  );

  bif_sync #(.STAGES(SYNC_STAGES)) u_rdsync (
    .clk (clk), .rst_n (rst_n), .din (rd_act), .level (rd_lvl), .level_prev (rd_prev)
  );
  bif_sync #(.STAGES(SYNC_STAGES)) u_wrsync (
    .clk (clk), .rst_n (rst_n), .din (wr_act), .level (wr_lvl), .level_prev (wr_prev)
  );

  assign rd_start = rd_lvl & ~rd_prev;
  assign rd_end   = ~rd_lvl & rd_prev;
  assign wr_start = wr_lvl & ~wr_prev;

  // Address of the read in progress, held for the side-effect pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_addr_q <= '0;
    else if (rd_start) rd_addr_q <= addr;
  end

  assign len_mask    = (addr == AW'(DATA_REG)) ? clen_mask(char_len) : {DW{1'b1}};
  assign reg_rd_addr = addr;
  assign rd_val      = reg_rd_data & len_mask;
  assign dbus        = rd_act ? rd_val : {DW{1'bz}};
  assign reg_wr_data = dbus & len_mask;

  bif_onehot_dec #(.AW(AW)) u_wrdec (
    .clk (clk), .rst_n (rst_n), .en (wr_start), .idx (addr), .hot (reg_wr_enable)
  );
  bif_onehot_dec #(.AW(AW)) u_rddec (
    .clk (clk), .rst_n (rst_n), .en (rd_end), .idx (rd_addr_q), .hot (reg_rd_done)
  );

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_enable) |=> !(|reg_wr_enable));
  p_wr_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wr_enable) |-> wr_lvl);
  p_rd_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_rd_done) |=> !(|reg_rd_done));
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lvl |=> (rd_addr_q == $past(rd_addr_q)) || $past(rd_start));
  p_wr_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_enable[DATA_REG] && char_len == CLEN5) |-> (reg_wr_data[DW-1:5] == '0));
endmodule

// File: tb/bif_top_tb_top.sv
module bif_top_tb_top;
  typedef struct packed {
    logic [2:0] idx;
    logic [7:0] data;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_hi = 1'b0, rd_lo_n = 1'b1, wr_hi = 1'b0, wr_lo_n = 1'b1;
  logic       cs_a = 1'b1, cs_b = 1'b1, cs_c_n = 1'b0;
  logic [2:0] addr = '0;
  logic [1:0] char_len = 2'd3;
  logic       tb_drv = 1'b1;
  logic [7:0] tb_val = 8'h00;
  wire  [7:0] dbus;
  logic [2:0] reg_rd_addr;
  logic [7:0] reg_rd_data;
  logic [7:0] reg_wr_enable, reg_wr_data, reg_rd_done;

  int tests = 0, fails = 0;
  int wr_seen = 0, rd_seen = 0;
  bit both_seen = 0, done = 0;
  ev_t wr_q[$];
  logic [2:0] rd_q[$];

  always #5 clk = ~clk;

  assign dbus = tb_drv ? tb_val : 8'bz;

  function automatic logic [7:0] rf_val(input logic [2:0] a);
    return 8'hE3 ^ {a, 5'b0} ^ {5'b0, a};
  endfunction
  function automatic logic [7:0] lmask(input logic [2:0] a, input logic [1:0] cl);
    if (a != 3'd0) return 8'hFF;
    return 8'hFF >> (3 - cl);
  endfunction

  assign reg_rd_data = rf_val(reg_rd_addr);

  bif_top dut_i (
    .clk (clk), .rst_n (rst_n), .rd_hi (rd_hi), .rd_lo_n (rd_lo_n),
    .wr_hi (wr_hi), .wr_lo_n (wr_lo_n), .cs_a (cs_a), .cs_b (cs_b),
    .cs_c_n (cs_c_n), .addr (addr), .dbus (dbus), .char_len (char_len),
    .reg_rd_addr (reg_rd_addr), .reg_rd_data (reg_rd_data),
    .reg_wr_enable (reg_wr_enable), .reg_wr_data (reg_wr_data),
    .reg_rd_done (reg_rd_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares pulses against the scoreboard queues
  initial begin
    forever begin
      @(posedge clk); #3;
      if (rst_n && reg_wr_enable != 0 && reg_rd_done != 0) both_seen = 1;
      if (rst_n && reg_wr_enable != 0) begin
        wr_seen++;
        if (wr_q.size() == 0) chk(0, "R2/R3 unexpected write pulse", 32'(reg_wr_enable), 0);
        else begin
          ev_t e;
          e = wr_q.pop_front();
          chk(reg_wr_enable == (8'd1 << e.idx), "R4 write enable index", 32'(reg_wr_enable), 32'(8'd1 << e.idx));
          chk(reg_wr_data == e.data, "R2/R7 write data", 32'(reg_wr_data), 32'(e.data));
        end
      end
      if (rst_n && reg_rd_done != 0) begin
        rd_seen++;
        if (rd_q.size() == 0) chk(0, "R9 unexpected read-done pulse", 32'(reg_rd_done), 0);
        else begin
          logic [2:0] ra;
          ra = rd_q.pop_front();
          chk(reg_rd_done == (8'd1 << ra), "R9 read-done index", 32'(reg_rd_done), 32'(8'd1 << ra));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input bit use_lo,
                          input logic [1:0] cl, input int hold);
    @(negedge clk);
    addr = a; tb_drv = 1; tb_val = d; char_len = cl;
    wr_q.push_back('{idx: a, data: d & lmask(a, cl)});
    if (use_lo) wr_lo_n = 0; else wr_hi = 1;
    repeat (hold) @(negedge clk);
    wr_lo_n = 1; wr_hi = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] a, input bit use_lo, input logic [1:0] cl);
    logic [7:0] exp;
    @(negedge clk);
    tb_drv = 0; addr = a; char_len = cl;
    if (use_lo) rd_lo_n = 0; else rd_hi = 1;
    #1;
    exp = rf_val(a) & lmask(a, cl);
    chk(reg_rd_addr == a, "R4 read address", 32'(reg_rd_addr), 32'(a));
    chk(dbus == exp, (a == 0) ? "R8 masked read data" : "R1 read data", 32'(dbus), 32'(exp));
    rd_q.push_back(a);
    repeat (3) @(negedge clk);
    rd_hi = 0; rd_lo_n = 1;
    repeat (4) @(negedge clk);
    tb_drv = 1;
  endtask

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    // Reset state
    chk(reg_wr_enable == 0, "R6 reset write enables", 32'(reg_wr_enable), 0);
    chk(reg_rd_done == 0, "R9 reset read-done", 32'(reg_rd_done), 0);
    rst_n = 1;
    @(negedge clk);
    tb_val = 8'h5A;
    #1 chk(dbus == 8'h5A, "R5 idle bus released", 32'(dbus), 32'h5A);

    // R6: exact latency and width of a write pulse
    @(negedge clk);
    addr = 3'd3; tb_val = 8'hC7; char_len = 2'd3;
    wr_q.push_back('{idx: 3'd3, data: 8'hC7});
    wr_hi = 1;
    @(posedge clk); #3 chk(reg_wr_enable == 0, "R6 no pulse after first edge", 32'(reg_wr_enable), 0);
    @(posedge clk); #3 chk(reg_wr_enable == 8'h08, "R6 pulse after second edge", 32'(reg_wr_enable), 32'h08);
    @(posedge clk); #3 chk(reg_wr_enable == 0, "R6 pulse one cycle", 32'(reg_wr_enable), 0);
    repeat (8) @(negedge clk);
    wr_hi = 0;
    repeat (4) @(negedge clk);

    // R2: both polarities, long strobe
    do_write(3'd5, 8'h3C, 1, 2'd3, 12);
    do_write(3'd6, 8'hFF, 0, 2'd1, 2);
    // R7: data register masking by length
    do_write(3'd0, 8'hFF, 0, 2'd3, 2);
    do_write(3'd0, 8'hFF, 1, 2'd0, 2);
    do_write(3'd0, 8'hB6, 0, 2'd2, 2);

    // R1 / R8 reads in both polarities
    do_read(3'd2, 0, 2'd3);
    do_read(3'd7, 1, 2'd3);
    do_read(3'd0, 0, 2'd1);
    do_read(3'd0, 1, 2'd0);

    // R3: each chip-select line deasserted in turn
    w0 = wr_seen; r0 = rd_seen;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cs_a = (k != 0); cs_b = (k != 1); cs_c_n = (k == 2);
      addr = 3'd5; tb_drv = 1; tb_val = 8'h00;
      rd_hi = 1; wr_lo_n = 0;
      #1 chk(dbus == 8'h00, "R3 bus not driven without chip select", 32'(dbus), 0);
      repeat (4) @(negedge clk);
      rd_hi = 0; wr_lo_n = 1;
      repeat (4) @(negedge clk);
    end
    cs_a = 1; cs_b = 1; cs_c_n = 0;
    chk(wr_seen == w0, "R3 no write pulse without chip select", 32'(wr_seen - w0), 0);
    chk(rd_seen == r0, "R3 no read-done without chip select", 32'(rd_seen - r0), 0);

    // R10: read ends as write starts
    @(negedge clk);
    tb_drv = 0; addr = 3'd4; rd_lo_n = 0;
    rd_q.push_back(3'd4);
    repeat (4) @(negedge clk);
    rd_lo_n = 1; addr = 3'd1; tb_drv = 1; tb_val = 8'h96; wr_hi = 1;
    wr_q.push_back('{idx: 3'd1, data: 8'h96});
    repeat (5) @(negedge clk);
    wr_hi = 0;
    repeat (5) @(negedge clk);
    chk(both_seen, "R10 read-done and write in same cycle", 32'(both_seen), 1);

    chk(wr_q.size() == 0, "R2/R6 all writes pulsed once", 32'(wr_q.size()), 0);
    chk(rd_q.size() == 0, "R9 all reads completed", 32'(rd_q.size()), 0);
    finish_run();
  end
endmodule